// File: doc/BRIEF.md
# Shortest-Form Vector Prefix Encoder

This block turns one decoded vector instruction description into a byte stream: a vector-extension prefix in its shortest legal form, then the opcode byte, then the ModRM byte. The description is given as plain fields: the operand-size bit W, the three register-extension bits R, X and B in their natural (non-complemented) sense, a map selector, a 4-bit register number for the extra source operand, the vector-length bit, the 2-bit implied-prefix code, the opcode and the ModRM byte. A force-long input makes the block emit the three-byte prefix even when the two-byte one would do.

A request is taken with a valid/ready handshake. The bytes then leave one per transfer on a valid/ready output with a last flag. While they are sent, a side output gives the prefix length that was chosen (2 or 3). The block takes no new request until the final byte of the current instruction has been transferred. If the map selector holds an unsupported value, the block raises an error pulse and emits no bytes.

Top module: `vpfx_encoder`

## Requirements
- R1: The three-byte form (leader byte 0xC4, 5 bytes in total) is emitted when W=1, when the natural X bit is 1, when the natural B bit is 1, or when the map is not the 0F map.
- R2: In every other case with force_long=0, the two-byte form (leader byte 0xC5, 4 bytes in total) is emitted.
- R3: With force_long=1, any request with a legal map is emitted in the three-byte form.
- R4: Three-byte layout: byte 1 is {~R, ~X, ~B, map code}, where the map code is 00001 for 0F, 00010 for 0F38 and 00011 for 0F3A. Byte 2 is {W, ~vvvv, L, pp}. Byte 3 is the opcode and byte 4 is ModRM.
- R5: Two-byte layout: byte 1 is {~R, ~vvvv, L, pp}. Byte 2 is the opcode and byte 3 is ModRM.
- R6: map_sel encodes 0 as 0F, 1 as 0F38 and 2 as 0F3A. An accepted request with map_sel=3 makes err high for exactly the next cycle, produces no output bytes, and leaves req_ready high.
- R7: req_ready is high whenever no instruction is pending. It is low from the cycle after acceptance until the cycle after the last byte is transferred.
- R8: While out_valid is high and out_ready is low, out_byte, out_last and pfx_len hold their values.
- R9: out_last is high only on the final byte of an instruction. pfx_len reads 3 or 2 while out_valid is high, and 0 otherwise.
- R10: After reset, out_valid=0, req_ready=1 and err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Encoder idle, request will be taken |
| req_w | input | 1 | Operand-size bit W |
| req_r | input | 1 | Natural R extension bit |
| req_x | input | 1 | Natural X extension bit |
| req_b | input | 1 | Natural B extension bit |
| req_map | input | 2 | Map selector: 0=0F, 1=0F38, 2=0F3A, 3=illegal |
| req_vreg | input | 4 | Extra source register number |
| req_vlen | input | 1 | Vector-length bit L |
| req_pp | input | 2 | Implied-prefix code |
| req_opc | input | 8 | Opcode byte |
| req_modrm | input | 8 | ModRM byte |
| force_long | input | 1 | Emit the three-byte form regardless |
| out_valid | output | 1 | out_byte holds a byte |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Current stream byte |
| out_last | output | 1 | Current byte ends the instruction |
| pfx_len | output | 2 | Chosen prefix length, 0 when idle |
| err | output | 1 | One-cycle pulse for a rejected map |

## Verification
A wrong form choice shows up at once: the first byte after acceptance carries the wrong leader, and the byte count and the position of the last flag then disagree with the expected ones. A wrong bit in the packed layout, such as a missed complement or a swapped field, changes one specific byte position. A broken index or handshake state shows up within one transfer as a repeated or skipped byte, a byte that moves during a stall, or req_ready rising while bytes are still pending. The sweep covers every combination of W, R, X, B, map and force_long, with the other fields varied, under mixed stall patterns, plus the two reference encodings.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;

  localparam int BYTE_W     = 8;
  localparam int STREAM_MAX = 5;
  localparam int IDX_W      = $clog2(STREAM_MAX + 1);

  localparam logic [IDX_W-1:0]  LONG_N   = IDX_W'(5);
  localparam logic [IDX_W-1:0]  SHORT_N  = IDX_W'(4);
  localparam logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4;
  localparam logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5;

  typedef logic [STREAM_MAX-1:0][BYTE_W-1:0] stream_t;

  typedef struct packed {
    logic              w;
    logic              ext_r;
    logic              ext_x;
    logic              ext_b;
    logic [1:0]        map;
    logic [3:0]        vreg;
    logic              vlen;
    logic [1:0]        pp;
    logic [BYTE_W-1:0] opc;
    logic [BYTE_W-1:0] modrm;
  } fields_t;

  function automatic logic [4:0] map_code(input logic [1:0] m);
    case (m)
      2'd0:    return 5'b00001;
      2'd1:    return 5'b00010;
      2'd2:    return 5'b00011;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic logic map_legal(input logic [1:0] m);
    return m != 2'd3;
  endfunction

  function automatic logic [BYTE_W-1:0] long_p1(input fields_t f);
    return {~f.ext_r, ~f.ext_x, ~f.ext_b, map_code(f.map)};
  endfunction

  function automatic logic [BYTE_W-1:0] long_p2(input fields_t f);
    return {f.w, ~f.vreg, f.vlen, f.pp};
  endfunction

  function automatic logic [BYTE_W-1:0] short_p1(input fields_t f);
    return {~f.ext_r, ~f.vreg, f.vlen, f.pp};
  endfunction

endpackage

// File: rtl/vpfx_form_select.sv
module vpfx_form_select (
  input  logic       w,
  input  logic       ext_x,
  input  logic       ext_b,
  input  logic [1:0] map,
  input  logic       force_long,
  output logic       use_long,
  output logic       map_ok
);
  import vpfx_pkg::*;

  logic needs_long;

  assign map_ok     = map_legal(map);
  assign needs_long = w | ext_x | ext_b | (map != 2'd0);
  assign use_long   = needs_long | force_long;

endmodule

// File: rtl/vpfx_packer.sv
module vpfx_packer (
  input  vpfx_pkg::fields_t                 f,
  input  logic                              use_long,
  output vpfx_pkg::stream_t                 slots,
  output logic [vpfx_pkg::IDX_W-1:0]        nbytes
);
  import vpfx_pkg::*;

  stream_t long_s;
  stream_t short_s;

  assign long_s  = {f.modrm, f.opc, long_p2(f), long_p1(f), LEAD_LONG};
  assign short_s = {8'h00, f.modrm, f.opc, short_p1(f), LEAD_SHORT};

  for (genvar i = 0; i < STREAM_MAX; i++) begin : g_slot
    assign slots[i] = use_long ? long_s[i] : short_s[i];
  end

  assign nbytes = use_long ? LONG_N : SHORT_N;

endmodule

// File: rtl/vpfx_serializer.sv
module vpfx_serializer (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                load,
  input  vpfx_pkg::stream_t                   load_bytes,
  input  logic [vpfx_pkg::IDX_W-1:0]          load_n,
  input  logic                                load_long,
  output logic                                busy,
  output logic                                first_beat,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [vpfx_pkg::BYTE_W-1:0]         out_byte,
  output logic                                out_last,
  output logic [1:0]                          pfx_len
);
  import vpfx_pkg::*;

  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  stream_t          buf_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] cnt_q;
  logic             long_q;
  logic             final_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      long_q <= 1'b0;
      buf_q  <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      idx_q  <= '0;
      cnt_q  <= load_n;
      long_q <= load_long;
      buf_q  <= load_bytes;
    end else if (busy && out_ready) begin
      if (final_beat) busy <= 1'b0;
      idx_q <= idx_q + IDX_ONE;
    end
  end

  function automatic logic [BYTE_W-1:0] pick(input stream_t s, input logic [IDX_W-1:0] i);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int k = 0; k < STREAM_MAX; k++)
      if (i == IDX_W'(k)) r = s[k];
    return r;
  endfunction

  assign final_beat = busy && (idx_q == cnt_q - IDX_ONE);
  assign first_beat = busy && (idx_q == '0);
  assign out_valid  = busy;
  assign out_byte   = pick(buf_q, idx_q);
  assign out_last   = final_beat;
  assign pfx_len    = busy ? (long_q ? 2'd3 : 2'd2) : 2'd0;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_ready) |=> (busy && $stable(out_byte) && $stable(out_last) && $stable(pfx_len)));

  // R9
  last_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  // R9
  len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pfx_len == 2'd2 || pfx_len == 2'd3));

endmodule

// File: rtl/vpfx_encoder.sv
module vpfx_encoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_w,
  input  logic       req_r,
  input  logic       req_x,
  input  logic       req_b,
  input  logic [1:0] req_map,
  input  logic [3:0] req_vreg,
  input  logic       req_vlen,
  input  logic [1:0] req_pp,
  input  logic [7:0] req_opc,
  input  logic [7:0] req_modrm,
  input  logic       force_long,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte,
  output logic       out_last,
  output logic [1:0] pfx_len,
  output logic       err
);
  import vpfx_pkg::*;

  fields_t          f;
  logic             use_long;
  logic             map_ok;
  stream_t          slots;
  logic [IDX_W-1:0] nbytes;
  logic             busy;
  logic             first_beat;
  logic             accept;
  logic             load;
  logic             reject;

  assign f = '{w: req_w, ext_r: req_r, ext_x: req_x, ext_b: req_b, map: req_map,
               vreg: req_vreg, vlen: req_vlen, pp: req_pp, opc: req_opc, modrm: req_modrm};

  vpfx_form_select sel_i (
    .w(req_w), .ext_x(req_x), .ext_b(req_b), .map(req_map),
    .force_long(force_long), .use_long(use_long), .map_ok(map_ok)
  );

  vpfx_packer pack_i (
    .f(f), .use_long(use_long), .slots(slots), .nbytes(nbytes)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign load      = accept && map_ok;
  assign reject    = accept && !map_ok;

  vpfx_serializer ser_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_bytes(slots), .load_n(nbytes),
    .load_long(use_long), .busy(busy), .first_beat(first_beat),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_last(out_last), .pfx_len(pfx_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= reject;
  end

  // R7
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  // R6
  reject_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err && !out_valid && req_ready));

  // R1
  leader_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_beat |-> (out_byte == ((pfx_len == 2'd3) ? LEAD_LONG : LEAD_SHORT)));

  // R3
  force_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && force_long) |=> (pfx_len == 2'd3));

  // R6
  load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (out_valid && first_beat));

endmodule

// File: tb/vpfx_encoder_tb.sv
module vpfx_encoder_tb_top;
  import vpfx_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  fields_t    rf = '0;
  logic       force_long = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_byte;
  logic       out_last;
  logic [1:0] pfx_len;
  logic       err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  vpfx_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_w(rf.w), .req_r(rf.ext_r), .req_x(rf.ext_x), .req_b(rf.ext_b),
    .req_map(rf.map), .req_vreg(rf.vreg), .req_vlen(rf.vlen), .req_pp(rf.pp),
    .req_opc(rf.opc), .req_modrm(rf.modrm), .force_long(force_long),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_last(out_last), .pfx_len(pfx_len), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic send(input fields_t f, input bit fl, input int sel);
    int    e[5];
    int    n;
    bit    lng;
    bit    natural_long;
    string tag;
    int    idx;
    bit    stalled;
    int    prev;
    natural_long = f.w || f.ext_x || f.ext_b || (f.map != 0);
    lng = natural_long || fl;
    if (lng) begin
      n = 5;
      e[0] = 196;
      e[1] = (1 - f.ext_r) * 128 + (1 - f.ext_x) * 64 + (1 - f.ext_b) * 32 + (int'(f.map) + 1);
      e[2] = f.w * 128 + (15 - int'(f.vreg)) * 8 + f.vlen * 4 + int'(f.pp);
      e[3] = f.opc;
      e[4] = f.modrm;
      tag = (fl && !natural_long) ? "R3" : "R1/R4";
    end else begin
      n = 4;
      e[0] = 197;
      e[1] = (1 - f.ext_r) * 128 + (15 - int'(f.vreg)) * 8 + f.vlen * 4 + int'(f.pp);
      e[2] = f.opc;
      e[3] = f.modrm;
      e[4] = 0;
      tag = "R2/R5";
    end
    rf = f;
    force_long = fl;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (f.map == 2'd3) begin
      chk(err == 1'b1, "R6 err pulse", err, 1);
      chk(out_valid == 1'b0, "R6 no bytes", out_valid, 0);
      chk(req_ready == 1'b1, "R6 ready stays", req_ready, 1);
      @(posedge clk);
      @(negedge clk);
      chk(err == 1'b0 && out_valid == 1'b0, "R6 single pulse", {err, out_valid}, 0);
      return;
    end
    idx = 0;
    stalled = 0;
    prev = 0;
    for (int g = 0; g < 60 && idx < n; g++) begin
      if (!out_valid) begin
        chk(0, "R7 out_valid missing", 0, 1);
        break;
      end
      if (req_ready) chk(0, "R7 ready while busy", 1, 0);
      if (stalled) chk(out_byte == prev, "R8 stall hold", out_byte, prev);
      out_ready = ((g + sel) % 3) != 2;
      if (out_ready) begin
        chk(out_byte == e[idx], tag, out_byte, e[idx]);
        chk(out_last == (idx == n - 1), "R9 last flag", out_last, idx == n - 1);
        chk(pfx_len == (lng ? 3 : 2), "R9 pfx_len", pfx_len, lng ? 3 : 2);
        idx++;
        stalled = 0;
      end else begin
        stalled = 1;
        prev = out_byte;
      end
      @(posedge clk);
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(idx == n, "R9 byte count", idx, n);
    chk(out_valid == 1'b0 && req_ready == 1'b1, "R7 idle after last",
        {out_valid, req_ready}, 1);
    chk(pfx_len == 2'd0, "R9 pfx_len idle", pfx_len, 0);
  endtask

  initial begin
    fields_t f;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    chk(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
    chk(err == 1'b0, "R10 err", err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // reference encodings: rm register 13, then rm register 3
    f = '0;
    f.ext_b = 1'b1; f.vreg = 4'd1; f.vlen = 1'b1; f.opc = 8'h58; f.modrm = 8'hC5;
    send(f, 1'b0, 0);
    f.ext_b = 1'b0; f.modrm = 8'hC3;
    send(f, 1'b0, 1);

    // full sweep over W, R, X, B, map and force_long
    for (int c = 0; c < 128; c++) begin
      f.w     = c[0];
      f.ext_r = c[1];
      f.ext_x = c[2];
      f.ext_b = c[3];
      f.map   = c[5:4];
      f.vreg  = 4'(c ^ (c >> 3));
      f.vlen  = c[1] ^ c[6];
      f.pp    = 2'(c + (c >> 2));
      f.opc   = 8'(c * 37 + 5);
      f.modrm = 8'(c * 11 + 3);
      send(f, c[6], c % 3);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule